// File: doc/BRIEF.md
# Speculative Virtual-Channel Switch Allocator

This block decides, every cycle, which input virtual channels of a five-port mesh router may send a flit through the crossbar. It runs in the same cycle as virtual-channel allocation. A channel that already owns a downstream VC bids with a firm request. A head flit that is still competing for a downstream VC may bid speculatively, on the assumption that it will win that VC. Firm requests always come before speculative ones. A speculative winner whose VC allocation fails in the same cycle is cancelled, so its crossbar slot stays idle for that cycle.

Allocation is separable. A round-robin choice inside each input picks one VC. A round-robin choice at each output then picks one input. Fairness pointers move only for grants that really send a flit. Route results, the held downstream VC, credit availability and the VC-allocation outcome all arrive as inputs. The grant results are combinational from those inputs, so router traversal fits in one clock.

Top module: `spec_sw_alloc`

## Requirements
- R1: While `rst_n` is low, no grant is issued (`gnt_valid` and `xbar_sel` are all zero). After reset, every input and output pointer favours index 0, and the search order rises from there.
- R2: Each cycle, every output row of `xbar_sel` (bits o*NPORT .. o*NPORT+NPORT-1) has at most one bit set. Each input has at most one bit set across all rows. `gnt_valid[i]` is high exactly when input i has a bit set.
- R3: Inside an input, a VC with an eligible firm request (`req_spec` low) is chosen before any VC with a speculative request (`req_spec` high).
- R4: At an output, an input whose chosen VC is firm wins over every input whose chosen VC is speculative, whatever the round-robin pointer.
- R5: A firm request from VC v of input i is eligible only when `credit_ok[o*NVC+c]` is high, where o is its destination port and c is its held downstream VC. Without that credit it cannot be granted.
- R6: A speculative winner whose `vca_ok[i*NVC+v]` is low in the same cycle is aborted. `gnt_valid[i]` is low, and no `xbar_sel` bit is set for input i.
- R7: Inside an input, after a committed grant to VC v, the next search starts at VC (v+1) mod NVC.
- R8: At an output, after a committed grant to input i, the next search starts at input (i+1) mod NPORT.
- R9: An aborted grant moves neither the input pointer nor the output pointer.
- R10: `gnt_vc[i*VW +: VW]` gives the index of the granted VC when `gnt_valid[i]` is high. That VC has `req_valid` set. The field is zero when there is no grant.
- R11: A request whose destination field is NPORT or larger is ignored.
- R12: Grants depend combinationally on the same cycle's inputs. Only the pointers are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORT*NVC | Per input VC: a flit is buffered and bidding (index i*NVC+v) |
| req_spec | input | NPORT*NVC | Per input VC: the bid is speculative |
| req_port | input | NPORT*NVC*PW | Per input VC: destination output port |
| req_ovc | input | NPORT*NVC*VW | Per input VC: held downstream VC (for firm bids) |
| credit_ok | input | NPORT*NVC | Per output and downstream VC: at least one credit (index o*NVC+c) |
| vca_ok | input | NPORT*NVC | Per input VC: VC allocation succeeded this cycle |
| xbar_sel | output | NPORT*NPORT | Crossbar select, bit o*NPORT+i connects input i to output o |
| gnt_vc | output | NPORT*VW | Per input: granted VC index |
| gnt_valid | output | NPORT | Per input: committed grant, already masked by abort |

## Verification
Every grant output depends on the inputs of the same cycle. The bench therefore drives the inputs just after a falling edge and reads the results two nanoseconds later, before the rising edge that could move a pointer. Pointer effects are checked on the cycle after the commit, by driving the same requests again and observing which VC or input now wins. A reference model in the bench keeps its own pointers. It advances them only on the grants it expects to commit, so an aborted cycle followed by an identical request shows whether any pointer moved by mistake.

// File: rtl/sa_pkg.sv
`timescale 1ns/1ps
package sa_pkg;
   function automatic int wrap_inc(input int idx, input int n);
      return (idx + 1 >= n) ? 0 : idx + 1;
   endfunction
endpackage

// File: rtl/sa_rr_pick.sv
`timescale 1ns/1ps
module sa_rr_pick #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] ptr,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      gnt = '0;
      any = |req;
      for (int k = N - 1; k >= 0; k--) begin
         int j;
         j = (int'(ptr) + k) % N;
         if (req[j]) idx = IW'(j);
      end
      if (any) gnt[idx] = 1'b1;
   end
endmodule

// File: rtl/sa_in_stage.sv
`timescale 1ns/1ps
module sa_in_stage #(
   parameter int NPORT = 5,
   parameter int NVC   = 4,
   parameter int PW    = 3,
   parameter int VW    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NVC-1:0]       v_req,
   input  logic [NVC-1:0]       v_spec,
   input  logic [NVC*PW-1:0]    v_port,
   input  logic [NVC*VW-1:0]    v_ovc,
   input  logic [NPORT*NVC-1:0] credit_ok,
   input  logic                 commit,
   output logic                 has,
   output logic                 is_ns,
   output logic [PW-1:0]        sel_port,
   output logic [VW-1:0]        sel_vc
);
   logic [NVC-1:0] ns_el, sp_el, cand, pick_oh;
   logic [VW-1:0]  ptr;

   always_comb begin
      for (int v = 0; v < NVC; v++) begin
         int p, c, ci;
         logic route_ok;
         p        = int'(v_port[v*PW +: PW]);
         c        = int'(v_ovc[v*VW +: VW]);
         route_ok = (p < NPORT);
         ci       = route_ok ? (p * NVC + c) : 0;
         ns_el[v] = v_req[v] & ~v_spec[v] & route_ok & credit_ok[ci];
         sp_el[v] = v_req[v] & v_spec[v] & route_ok;
      end
      cand  = (|ns_el) ? ns_el : sp_el;
      is_ns = |ns_el;
   end

   sa_rr_pick #(.N(NVC), .IW(VW)) u_pick (
      .req(cand), .ptr(ptr), .gnt(pick_oh), .idx(sel_vc), .any(has)
   );

   assign sel_port = v_port[sel_vc*PW +: PW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr <= '0;
      else if (commit) ptr <= VW'(sa_pkg::wrap_inc(int'(sel_vc), NVC));
   end

   p_in_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(ptr));
   p_in_firm_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (has && is_ns) |-> (v_req[sel_vc] && !v_spec[sel_vc]));
   p_in_commit_has_r10: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (has && $onehot0(pick_oh)));
endmodule

// File: rtl/sa_out_stage.sv
`timescale 1ns/1ps
module sa_out_stage #(
   parameter int NPORT = 5,
   parameter int PW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPORT-1:0] req,
   input  logic [NPORT-1:0] ns,
   input  logic             commit,
   output logic [NPORT-1:0] gnt
);
   logic [NPORT-1:0] cand;
   logic [PW-1:0]    ptr, win;
   logic             any;

   assign cand = (|(req & ns)) ? (req & ns) : req;

   sa_rr_pick #(.N(NPORT), .IW(PW)) u_pick (
      .req(cand), .ptr(ptr), .gnt(gnt), .idx(win), .any(any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr <= '0;
      else if (commit) ptr <= PW'(sa_pkg::wrap_inc(int'(win), NPORT));
   end

   p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(ptr));
   p_out_firm_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(req & ns)) |-> (|(gnt & ns)));
   p_out_commit_any_r2: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (any && $onehot(gnt)));
endmodule

// File: rtl/spec_sw_alloc.sv
`timescale 1ns/1ps
module spec_sw_alloc #(
   parameter int NPORT = 5,
   parameter int NVC   = 4,
   parameter int PW    = (NPORT > 1) ? $clog2(NPORT) : 1,
   parameter int VW    = (NVC > 1) ? $clog2(NVC) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPORT*NVC-1:0]     req_valid,
   input  logic [NPORT*NVC-1:0]     req_spec,
   input  logic [NPORT*NVC*PW-1:0]  req_port,
   input  logic [NPORT*NVC*VW-1:0]  req_ovc,
   input  logic [NPORT*NVC-1:0]     credit_ok,
   input  logic [NPORT*NVC-1:0]     vca_ok,
   output logic [NPORT*NPORT-1:0]   xbar_sel,
   output logic [NPORT*VW-1:0]      gnt_vc,
   output logic [NPORT-1:0]         gnt_valid
);
   if (NPORT < 2 || NVC < 2) begin : g_bad_size
      $error("spec_sw_alloc: NPORT and NVC must each be at least 2");
   end
   if (PW < $clog2(NPORT) || VW < $clog2(NVC)) begin : g_bad_width
      $error("spec_sw_alloc: index widths too narrow");
   end

   logic [NPORT-1:0] in_has, in_ns, commit_in, commit_out;
   logic [PW-1:0]    in_port [NPORT];
   logic [VW-1:0]    in_vc   [NPORT];
   logic [NPORT-1:0] o_req   [NPORT];
   logic [NPORT-1:0] o_gnt   [NPORT];

   for (genvar i = 0; i < NPORT; i++) begin : g_in
      sa_in_stage #(.NPORT(NPORT), .NVC(NVC), .PW(PW), .VW(VW)) u_in (
         .clk      (clk),
         .rst_n    (rst_n),
         .v_req    (req_valid[i*NVC +: NVC]),
         .v_spec   (req_spec[i*NVC +: NVC]),
         .v_port   (req_port[i*NVC*PW +: NVC*PW]),
         .v_ovc    (req_ovc[i*NVC*VW +: NVC*VW]),
         .credit_ok(credit_ok),
         .commit   (commit_in[i]),
         .has      (in_has[i]),
         .is_ns    (in_ns[i]),
         .sel_port (in_port[i]),
         .sel_vc   (in_vc[i])
      );
   end

   always_comb begin
      for (int o = 0; o < NPORT; o++)
         for (int i = 0; i < NPORT; i++)
            o_req[o][i] = in_has[i] && (int'(in_port[i]) == o);
   end

   for (genvar o = 0; o < NPORT; o++) begin : g_out
      sa_out_stage #(.NPORT(NPORT), .PW(PW)) u_out (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (o_req[o]),
         .ns    (in_ns),
         .commit(commit_out[o]),
         .gnt   (o_gnt[o])
      );
   end

   always_comb begin
      for (int i = 0; i < NPORT; i++) begin
         logic won;
         won = 1'b0;
         for (int o = 0; o < NPORT; o++) won = won | o_gnt[o][i];
         commit_in[i] = rst_n & won & (in_ns[i] | vca_ok[i*NVC + int'(in_vc[i])]);
      end
   end

   always_comb begin
      for (int o = 0; o < NPORT; o++) begin
         commit_out[o] = |(o_gnt[o] & commit_in);
         for (int i = 0; i < NPORT; i++)
            xbar_sel[o*NPORT + i] = o_gnt[o][i] & commit_in[i];
      end
      for (int i = 0; i < NPORT; i++)
         gnt_vc[i*VW +: VW] = commit_in[i] ? in_vc[i] : '0;
   end

   assign gnt_valid = commit_in;

   p_quiet_in_reset_r1: assert property (@(posedge clk)
      !rst_n |-> (gnt_valid == '0 && xbar_sel == '0));

   for (genvar o = 0; o < NPORT; o++) begin : g_row_chk
      p_row_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(xbar_sel[o*NPORT +: NPORT]));
   end

   for (genvar i = 0; i < NPORT; i++) begin : g_col_chk
      logic [NPORT-1:0] col;
      always_comb for (int o = 0; o < NPORT; o++) col[o] = xbar_sel[o*NPORT + i];
      p_col_matches_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(col) && ((|col) == gnt_valid[i]));
      p_gnt_has_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
         gnt_valid[i] |-> req_valid[i*NVC + int'(gnt_vc[i*VW +: VW])]);
      p_spec_needs_vca_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt_valid[i] && req_spec[i*NVC + int'(gnt_vc[i*VW +: VW])])
            |-> vca_ok[i*NVC + int'(gnt_vc[i*VW +: VW])]);
   end
endmodule

// File: tb/spec_sw_alloc_tb.sv
`timescale 1ns/1ps
module spec_sw_alloc_tb;
   localparam int P = 5, V = 4, PW = 3, VW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [P*V-1:0]    req_valid = '0, req_spec = '0, credit_ok = '0, vca_ok = '0;
   logic [P*V*PW-1:0] req_port = '0;
   logic [P*V*VW-1:0] req_ovc = '0;
   logic [P*P-1:0]    xbar_sel;
   logic [P*VW-1:0]   gnt_vc;
   logic [P-1:0]      gnt_valid;

   spec_sw_alloc #(.NPORT(P), .NVC(V)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_spec(req_spec),
      .req_port(req_port), .req_ovc(req_ovc), .credit_ok(credit_ok),
      .vca_ok(vca_ok), .xbar_sel(xbar_sel), .gnt_vc(gnt_vc), .gnt_valid(gnt_valid)
   );

   always #4 clk = ~clk;

   int n_chk = 0, n_err = 0;
   int ip[P], op[P];
   bit e_val[P];
   int e_vc[P];
   bit e_x[P][P];

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic report;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      chk(1'b0, "WATCHDOG", "run timed out", 0, 1);
      report();
   end

   function automatic int fport(int i, int v);
      return int'(req_port[(i*V+v)*PW +: PW]);
   endfunction

   function automatic bit firm_ok(int i, int v);
      int p, c;
      p = fport(i, v);
      c = int'(req_ovc[(i*V+v)*VW +: VW]);
      if (!req_valid[i*V+v] || req_spec[i*V+v] || p >= P) return 1'b0;
      return credit_ok[p*V+c];
   endfunction

   function automatic bit spec_ok(int i, int v);
      return req_valid[i*V+v] && req_spec[i*V+v] && fport(i, v) < P;
   endfunction

   task automatic model_eval;
      bit has[P], fm[P];
      int cv[P];
      int win[P];
      for (int i = 0; i < P; i++) begin
         has[i] = 0; fm[i] = 0; cv[i] = 0;
         for (int k = 0; k < V && !has[i]; k++)
            if (firm_ok(i, (ip[i]+k)%V)) begin has[i] = 1; fm[i] = 1; cv[i] = (ip[i]+k)%V; end
         for (int k = 0; k < V && !has[i]; k++)
            if (spec_ok(i, (ip[i]+k)%V)) begin has[i] = 1; cv[i] = (ip[i]+k)%V; end
      end
      for (int o = 0; o < P; o++) begin
         win[o] = -1;
         for (int k = 0; k < P && win[o] < 0; k++) begin
            int j;
            j = (op[o]+k)%P;
            if (has[j] && fm[j] && fport(j, cv[j]) == o) win[o] = j;
         end
         for (int k = 0; k < P && win[o] < 0; k++) begin
            int j;
            j = (op[o]+k)%P;
            if (has[j] && fport(j, cv[j]) == o) win[o] = j;
         end
      end
      for (int i = 0; i < P; i++) begin
         bit w;
         w = has[i] && win[fport(i, cv[i]) % 8 < P ? fport(i, cv[i]) : 0] == i;
         e_val[i] = w && (fm[i] || vca_ok[i*V+cv[i]]);
         e_vc[i]  = e_val[i] ? cv[i] : 0;
      end
      for (int o = 0; o < P; o++)
         for (int i = 0; i < P; i++)
            e_x[o][i] = (win[o] == i) && e_val[i];
   endtask

   task automatic model_commit;
      for (int i = 0; i < P; i++) if (e_val[i]) ip[i] = (e_vc[i]+1)%V;
      for (int o = 0; o < P; o++)
         for (int i = 0; i < P; i++) if (e_x[o][i]) op[o] = (i+1)%P;
   endtask

   task automatic compare_model;
      model_eval();
      for (int i = 0; i < P; i++) begin
         int col;
         col = 0;
         chk(gnt_valid[i] == e_val[i], "R3 R5 R6", $sformatf("gnt_valid[%0d]", i),
             int'(gnt_valid[i]), int'(e_val[i]));
         chk(int'(gnt_vc[i*VW +: VW]) == e_vc[i], "R7 R10", $sformatf("gnt_vc[%0d]", i),
             int'(gnt_vc[i*VW +: VW]), e_vc[i]);
         for (int o = 0; o < P; o++) col += int'(xbar_sel[o*P+i]);
         chk(col <= 1 && (col == 1) == gnt_valid[i], "R2", $sformatf("column %0d count", i),
             col, int'(gnt_valid[i]));
      end
      for (int o = 0; o < P; o++) begin
         int row;
         row = $countones(xbar_sel[o*P +: P]);
         chk(row <= 1, "R2", $sformatf("row %0d count", o), row, 1);
         for (int i = 0; i < P; i++)
            chk(xbar_sel[o*P+i] == e_x[o][i], "R4 R8 R11",
                $sformatf("xbar[%0d][%0d]", o, i), int'(xbar_sel[o*P+i]), int'(e_x[o][i]));
      end
   endtask

   // inputs are set just after a falling edge; results read 2 ns later (R12)
   task automatic settle; #2; compare_model(); endtask
   task automatic advance; model_commit(); @(negedge clk); endtask

   task automatic clear_in;
      req_valid = '0; req_spec = '0; req_port = '0; req_ovc = '0;
      credit_ok = '0; vca_ok = '0;
   endtask

   task automatic put(input int i, input int v, input int port, input int ovc, input bit spec);
      req_valid[i*V+v] = 1'b1;
      req_spec[i*V+v]  = spec;
      req_port[(i*V+v)*PW +: PW] = PW'(port);
      req_ovc[(i*V+v)*VW +: VW]  = VW'(ovc);
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0;
      clear_in();
      put(0, 0, 1, 0, 0); credit_ok = '1; vca_ok = '1;
      #2;
      chk(gnt_valid == '0, "R1", "gnt_valid in reset", int'(gnt_valid), 0);
      chk(xbar_sel == '0, "R1", "xbar_sel in reset", int'(xbar_sel), 0);
      @(negedge clk);
      rst_n = 1'b1;
      clear_in();
      for (int k = 0; k < P; k++) begin ip[k] = 0; op[k] = 0; end
   endtask

   initial begin
      do_reset();

      // R1: pointers start at index 0
      put(0, 0, 1, 0, 0); put(0, 2, 1, 0, 0);
      put(3, 1, 4, 0, 0); put(4, 1, 4, 0, 0); credit_ok = '1;
      settle();
      chk(int'(gnt_vc[0 +: VW]) == 0, "R1", "input0 first VC", int'(gnt_vc[0 +: VW]), 0);
      chk(xbar_sel[4*P+3] == 1'b1, "R1", "output4 lowest input", int'(xbar_sel[4*P+3]), 1);
      advance();

      // R3: firm VC3 beats speculative VC0 inside input 1
      do_reset();
      put(1, 0, 2, 0, 1); put(1, 3, 2, 0, 0); credit_ok[2*V+0] = 1'b1; vca_ok = '1;
      settle();
      chk(gnt_valid[1] && int'(gnt_vc[1*VW +: VW]) == 3, "R3", "input1 VC",
          int'(gnt_vc[1*VW +: VW]), 3);
      advance();

      // R4: firm input 3 beats speculative input 2 at output 4
      do_reset();
      put(2, 0, 4, 0, 1); put(3, 1, 4, 0, 0); credit_ok[4*V+0] = 1'b1; vca_ok = '1;
      settle();
      chk(xbar_sel[4*P+3] == 1'b1, "R4", "firm input wins", int'(xbar_sel[4*P+3]), 1);
      chk(gnt_valid[2] == 1'b0, "R4", "speculative input loses", int'(gnt_valid[2]), 0);
      advance();

      // R5: no credit, no grant; then credit arrives
      do_reset();
      put(0, 0, 3, 1, 0); vca_ok = '1;
      settle();
      chk(gnt_valid[0] == 1'b0, "R5", "firm without credit", int'(gnt_valid[0]), 0);
      advance();
      credit_ok[3*V+1] = 1'b1;
      settle();
      chk(xbar_sel[3*P+0] == 1'b1, "R5", "firm with credit", int'(xbar_sel[3*P+0]), 1);
      advance();

      // R6 / R9 input pointer: abort, then same requests succeed at VC1, then VC2
      do_reset();
      put(4, 1, 0, 0, 1); put(4, 2, 0, 0, 1);
      settle();
      chk(gnt_valid[4] == 1'b0, "R6", "aborted speculative", int'(gnt_valid[4]), 0);
      chk(xbar_sel[0 +: P] == '0, "R6", "output0 idle on abort", int'(xbar_sel[0 +: P]), 0);
      advance();
      vca_ok = '1;
      settle();
      chk(int'(gnt_vc[4*VW +: VW]) == 1, "R9", "input pointer held", int'(gnt_vc[4*VW +: VW]), 1);
      advance();
      settle();
      chk(int'(gnt_vc[4*VW +: VW]) == 2, "R7", "input pointer moved on commit",
          int'(gnt_vc[4*VW +: VW]), 2);
      advance();

      // R9 output pointer: abort at output 2 then retry
      do_reset();
      put(0, 0, 2, 0, 1); put(1, 0, 2, 0, 1);
      settle();
      advance();
      vca_ok = '1;
      settle();
      chk(xbar_sel[2*P+0] == 1'b1, "R9", "output pointer held", int'(xbar_sel[2*P+0]), 1);
      advance();

      // R7: input 0 alternates VC0, VC1, VC0
      do_reset();
      put(0, 0, 1, 0, 0); put(0, 1, 1, 0, 0); credit_ok[1*V+0] = 1'b1;
      for (int n = 0; n < 3; n++) begin
         settle();
         chk(int'(gnt_vc[0 +: VW]) == n % 2, "R7", "input rotation",
             int'(gnt_vc[0 +: VW]), n % 2);
         advance();
      end

      // R8: output 0 alternates input 1, input 3, input 1
      do_reset();
      put(1, 0, 0, 0, 0); put(3, 0, 0, 0, 0); credit_ok[0] = 1'b1;
      for (int n = 0; n < 3; n++) begin
         settle();
         chk(xbar_sel[(n % 2 == 0) ? 1 : 3] == 1'b1, "R8", "output rotation",
             int'(xbar_sel[0 +: P]), (n % 2 == 0) ? 2 : 8);
         advance();
      end

      // R11: destination 6 is ignored
      do_reset();
      put(2, 0, 6, 0, 0); put(2, 1, 7, 0, 1); credit_ok = '1; vca_ok = '1;
      settle();
      chk(gnt_valid[2] == 1'b0, "R11", "out-of-range destination", int'(gnt_valid[2]), 0);
      chk(xbar_sel == '0, "R11", "crossbar idle", int'(xbar_sel), 0);
      advance();

      // sweep against the reference model at several loads
      do_reset();
      for (int ph = 0; ph < 4; ph++) begin
         for (int n = 0; n < 800; n++) begin
            for (int k = 0; k < P*V; k++) begin
               req_valid[k] = ($urandom % 100) < (20 + ph * 25);
               req_spec[k]  = $urandom % 2;
               req_port[k*PW +: PW] = PW'((ph == 0) ? $urandom % P : $urandom % 8);
               req_ovc[k*VW +: VW]  = VW'($urandom % V);
               credit_ok[k] = ($urandom % 100) < 75;
               vca_ok[k]    = $urandom % 2;
            end
            settle();
            advance();
         end
      end
      report();
   end
endmodule